// File: doc/BRIEF.md
# CAN Frame Acceptance Filter

This block decides whether a CAN frame that has just come off the bus should be kept by the receiver. It looks at the frame identifier, the extended-format and remote-request flags, the data length code and the first two data bytes. It checks them against four acceptance code bytes and four acceptance mask bytes. A mask bit at 1 makes the matching code bit a don't-care.

The same eight configuration bytes mean different things depending on the filter arrangement (single or dual) and on the frame format (standard 11-bit or extended 29-bit identifier). In single arrangement one wide filter covers the whole identifier, and for standard frames it can also test the data bytes. In dual arrangement two narrower filters are evaluated side by side and either of them may accept.

The receive path presents a frame with a one-cycle strobe. The verdict appears on the next cycle, together with a result-valid flag.

Top module: `can_accept_filter`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `frm_valid` high. `res_accept` is low whenever `res_valid` is low. Reset (synchronous, `rst_n` low) clears both outputs.
- R2: A mask bit of 1 makes the corresponding code bit irrelevant. With all 32 mask bits set, every frame is accepted in both arrangements.
- R3: Code byte k sits at `acc_code[8k+7:8k]`, and mask byte k sits at the same position of `acc_mask`. With `single_mode`=1 and an extended frame, identifier bits 28..21 are compared with byte 0, bits 20..13 with byte 1, bits 12..5 with byte 2 and bits 4..0 with byte 3 bits 7..3. Byte 3 bits 2..0 are unused.
- R4: With `single_mode`=1 and a standard frame, identifier bits 10..3 are compared with byte 0 and bits 2..0 with byte 1 bits 7..5. The remote flag is compared with byte 1 bit 4, and mask byte 1 bit 4 set ignores the remote flag.
- R5: In the case of R4, when the identifier matches, the frame is accepted at once if it is a remote frame or has length 0. Otherwise data byte 0 must match code byte 2 under mask byte 2. If the length is 1 that is enough; for a longer frame, data byte 1 must also match code byte 3 under mask byte 3.
- R6: With `single_mode`=0 and an extended frame, only identifier bits 28..13 are tested: against bytes 0 and 1 (first filter) and against bytes 2 and 3 (second filter). A hit in either filter accepts.
- R7: With `single_mode`=0 and a standard frame, the first filter compares the identifier and the remote flag with bytes 0 and 1, using the layout of R4. It also compares data byte 0 with the value {byte1[3:0], byte3[3:0]} under the mask {mask1[3:0], mask3[3:0]}. A frame of length 0 passes this data test.
- R8: With `single_mode`=0 and a standard frame, the second filter compares the identifier with byte 2 and byte 3 bits 7..5, and the remote flag with byte 3 bit 4 (masked by mask byte 3 bit 4). It applies no data test. Either filter accepting is enough.
- R9: `single_mode` picks the arrangement frame by frame. The same frame and configuration can be accepted in one arrangement and rejected in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | One-cycle strobe: frame fields are valid |
| frm_id | input | 29 | Identifier (standard frames use bits 10..0) |
| frm_ext | input | 1 | 1 = extended 29-bit identifier |
| frm_rtr | input | 1 | 1 = remote request frame |
| frm_dlc | input | 4 | Data length code |
| frm_d0 | input | 8 | First data byte |
| frm_d1 | input | 8 | Second data byte |
| acc_code | input | 32 | Acceptance code bytes 0..3 (byte k at bits 8k+7..8k) |
| acc_mask | input | 32 | Acceptance mask bytes 0..3, 1 = don't care |
| single_mode | input | 1 | 1 = single filter, 0 = dual filter |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_accept | output | 1 | 1 = frame accepted |

## Verification
The assertions check the following on every cycle:
- the result strobe tracks the frame strobe with one cycle of delay;
- no accept is raised without a result;
- a fully open mask always accepts;
- a dual-arrangement extended frame whose top sixteen identifier bits equal the first filter's bytes, with a closed mask, is always accepted.

Only the bench's scenarios can show that the bytes are decoded at the right bit positions. The same holds for the early acceptance of remote and empty standard frames and for the length-1 cut-off of the data check. The bench scenarios also cover the split-nibble data value of the dual first filter, the remote test of the second filter and the switch between arrangements.

// File: rtl/can_flt_pkg.sv
// Package: shared constants and helpers for the CAN acceptance filter.
// Assumes byte k of a 32-bit code/mask word lives at bits 8k+7..8k.
package can_flt_pkg;
    localparam int BYTE_W   = 8;
    localparam int N_BYTES  = 4;
    localparam int CFG_W    = BYTE_W * N_BYTES;
    localparam int EXT_ID_W = 29;
    localparam int STD_ID_W = 11;
    localparam int DLC_W    = 4;

    // Byte k of a configuration word.
    function automatic logic [BYTE_W-1:0] cfg_byte(input logic [CFG_W-1:0] w, input int k);
        return w[BYTE_W*k +: BYTE_W];
    endfunction

    // True when a equals b on every bit where the mask m is 0.
    function automatic logic byte_match(input logic [BYTE_W-1:0] a,
                                        input logic [BYTE_W-1:0] b,
                                        input logic [BYTE_W-1:0] m);
        return ((a ^ b) & ~m) == '0;
    endfunction
endpackage

// File: rtl/can_flt_single.sv
// Single-arrangement matcher: one wide filter over all four code/mask bytes.
// Extended frames compare the whole 29-bit identifier; standard frames
// compare identifier plus remote flag and may also test data bytes 0 and 1.
// Purely combinational; the caller registers the verdict.
module can_flt_single
    import can_flt_pkg::*;
(
    input  logic [EXT_ID_W-1:0] id,
    input  logic                ext,
    input  logic                rtr,
    input  logic [DLC_W-1:0]    dlc,
    input  logic [BYTE_W-1:0]   d0,
    input  logic [BYTE_W-1:0]   d1,
    input  logic [CFG_W-1:0]    code,
    input  logic [CFG_W-1:0]    mask,
    output logic                hit
);
    localparam int STD_CMP_W = STD_ID_W + 1;

    logic [EXT_ID_W-1:0]  ext_want, ext_dc;
    logic [STD_CMP_W-1:0] std_want, std_dc, std_have;
    logic                 ext_ok, std_id_ok, d0_ok, d1_ok, data_ok;

    // Lay the code and mask bytes out as identifier-aligned vectors.
    always_comb begin
        ext_want = {cfg_byte(code, 0), cfg_byte(code, 1), cfg_byte(code, 2), code[31:27]};
        ext_dc   = {cfg_byte(mask, 0), cfg_byte(mask, 1), cfg_byte(mask, 2), mask[31:27]};
        std_want = {cfg_byte(code, 0), code[15:12]};
        std_dc   = {cfg_byte(mask, 0), mask[15:12]};
        std_have = {id[STD_ID_W-1:0], rtr};
    end

    // Identifier, data-byte and final verdict terms.
    always_comb begin
        ext_ok    = ((id ^ ext_want) & ~ext_dc) == '0;
        std_id_ok = ((std_have ^ std_want) & ~std_dc) == '0;
        d0_ok     = byte_match(d0, cfg_byte(code, 2), cfg_byte(mask, 2));
        d1_ok     = byte_match(d1, cfg_byte(code, 3), cfg_byte(mask, 3));
        data_ok   = rtr || (dlc == '0) || (d0_ok && ((dlc == DLC_W'(1)) || d1_ok));
        hit       = ext ? ext_ok : (std_id_ok && data_ok);
    end
endmodule

// File: rtl/can_flt_dual.sv
// Dual-arrangement matcher: two narrow filters, bank g built from bytes 2g
// and 2g+1. Either bank accepting is enough. Extended frames test identifier
// bits 28..13 only; standard frames test identifier plus remote flag, and
// bank 0 also tests data byte 0 against nibbles split over bytes 1 and 3.
// Purely combinational.
module can_flt_dual
    import can_flt_pkg::*;
(
    input  logic [EXT_ID_W-1:0] id,
    input  logic                ext,
    input  logic                rtr,
    input  logic [DLC_W-1:0]    dlc,
    input  logic [BYTE_W-1:0]   d0,
    input  logic [CFG_W-1:0]    code,
    input  logic [CFG_W-1:0]    mask,
    output logic                hit
);
    localparam int N_BANKS   = 2;
    localparam int EXT_HI_W  = 2 * BYTE_W;
    localparam int STD_CMP_W = STD_ID_W + 1;

    logic [N_BANKS-1:0] ext_ok, std_ok;
    logic [BYTE_W-1:0]  nib_want, nib_dc;
    logic               data_ok;

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        logic [EXT_HI_W-1:0]  hi_want, hi_dc;
        logic [STD_CMP_W-1:0] s_want, s_dc;
        // Per-bank identifier comparison for both frame formats.
        always_comb begin
            hi_want   = {cfg_byte(code, 2*g), cfg_byte(code, 2*g+1)};
            hi_dc     = {cfg_byte(mask, 2*g), cfg_byte(mask, 2*g+1)};
            s_want    = {cfg_byte(code, 2*g), code[BYTE_W*(2*g+1)+4 +: 4]};
            s_dc      = {cfg_byte(mask, 2*g), mask[BYTE_W*(2*g+1)+4 +: 4]};
            ext_ok[g] = ((id[EXT_ID_W-1 -: EXT_HI_W] ^ hi_want) & ~hi_dc) == '0;
            std_ok[g] = (({id[STD_ID_W-1:0], rtr} ^ s_want) & ~s_dc) == '0;
        end
    end

    // Bank 0 data test on byte 0; empty frames pass it.
    always_comb begin
        nib_want = {code[11:8], code[27:24]};
        nib_dc   = {mask[11:8], mask[27:24]};
        data_ok  = (dlc == '0) || byte_match(d0, nib_want, nib_dc);
        hit      = ext ? (|ext_ok) : ((std_ok[0] && data_ok) || std_ok[1]);
    end
endmodule

// File: rtl/can_accept_filter.sv
// Top: CAN frame acceptance filter. Selects the single or dual matcher per
// frame and registers the verdict one cycle after the frame strobe.
// Assumes frame fields and configuration are stable in the strobe cycle.
module can_accept_filter
    import can_flt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic [EXT_ID_W-1:0] frm_id,
    input  logic                frm_ext,
    input  logic                frm_rtr,
    input  logic [DLC_W-1:0]    frm_dlc,
    input  logic [BYTE_W-1:0]   frm_d0,
    input  logic [BYTE_W-1:0]   frm_d1,
    input  logic [CFG_W-1:0]    acc_code,
    input  logic [CFG_W-1:0]    acc_mask,
    input  logic                single_mode,
    output logic                res_valid,
    output logic                res_accept
);
    logic hit_single, hit_dual, hit;

    can_flt_single u_single (
        .id(frm_id), .ext(frm_ext), .rtr(frm_rtr), .dlc(frm_dlc),
        .d0(frm_d0), .d1(frm_d1), .code(acc_code), .mask(acc_mask),
        .hit(hit_single)
    );

    can_flt_dual u_dual (
        .id(frm_id), .ext(frm_ext), .rtr(frm_rtr), .dlc(frm_dlc),
        .d0(frm_d0), .code(acc_code), .mask(acc_mask),
        .hit(hit_dual)
    );

    // Arrangement select.
    always_comb hit = single_mode ? hit_single : hit_dual;

    // Register the verdict and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_accept <= 1'b0;
        end else begin
            res_valid  <= frm_valid;
            res_accept <= frm_valid && hit;
        end
    end

    // R1: result strobe follows the frame strobe by one cycle.
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> res_valid);
    assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !res_valid && !res_accept);
    // R2: a fully open mask accepts anything.
    assert_open_mask_accepts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (&acc_mask)) |=> res_accept);
    // R6: dual extended frame hitting the first filter with a closed mask is kept.
    assert_dual_ext_bank0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !single_mode && frm_ext && acc_mask == '0 &&
         frm_id[28:13] == {acc_code[7:0], acc_code[15:8]}) |=> res_accept);
endmodule

// File: tb/can_accept_filter_tb.sv
// Scoreboard bench: the driver pushes hand-computed verdicts, the monitor
// pops and compares them when res_valid appears.
module can_accept_filter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frm_valid = 1'b0;
    logic [28:0] frm_id = '0;
    logic        frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [3:0]  frm_dlc = '0;
    logic [7:0]  frm_d0 = '0, frm_d1 = '0;
    logic [31:0] acc_code = '0, acc_mask = '0;
    logic        single_mode = 1'b0;
    logic        res_valid, res_accept;

    int checks = 0;
    int fails  = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    can_accept_filter u_dut (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_ext(frm_ext), .frm_rtr(frm_rtr), .frm_dlc(frm_dlc),
        .frm_d0(frm_d0), .frm_d1(frm_d1), .acc_code(acc_code),
        .acc_mask(acc_mask), .single_mode(single_mode),
        .res_valid(res_valid), .res_accept(res_accept)
    );

    function automatic logic [31:0] pack4(input logic [7:0] b0, b1, b2, b3);
        return {b3, b2, b1, b0};
    endfunction

    task automatic send(input logic [28:0] id, input logic ext, input logic rtr,
                        input logic [3:0] dlc, input logic [7:0] d0, input logic [7:0] d1,
                        input bit exp, input string tag);
        @(negedge clk);
        frm_id = id; frm_ext = ext; frm_rtr = rtr; frm_dlc = dlc;
        frm_d0 = d0; frm_d1 = d1; frm_valid = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    // Monitor: compare each result against the queue (R1 covers timing).
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && res_valid) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R1: unexpected res_valid, actual 1 expected 0");
                end else begin
                    automatic bit    e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (res_accept !== e) begin
                        fails++;
                        $display("FAIL %s: res_accept actual %b expected %b", t, res_accept, e);
                    end
                end
            end else if (rst_n && res_accept) begin
                checks++;
                fails++;
                $display("FAIL R1: res_accept without res_valid, actual 1 expected 0");
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || res_accept !== 1'b0) begin
            fails++;
            $display("FAIL R1: reset outputs actual %b%b expected 00", res_valid, res_accept);
        end
        rst_n = 1'b1;

        // R2: everything open.
        acc_code = 32'h0; acc_mask = 32'hFFFF_FFFF; single_mode = 1'b1;
        send(29'h1ABC_DEF1, 1, 0, 4'd8, 8'h00, 8'h00, 1, "R2");
        single_mode = 1'b0;
        send(29'h0000_0123, 0, 1, 4'd2, 8'h55, 8'hAA, 1, "R2");

        // R3: single, extended identifier.
        single_mode = 1'b1;
        acc_code = pack4(8'h12, 8'h34, 8'h56, 8'h78);
        acc_mask = pack4(8'h00, 8'h00, 8'h00, 8'h07);
        send({8'h12, 8'h34, 8'h56, 5'h0F}, 1, 0, 4'd0, 8'h0, 8'h0, 1, "R3");
        send({8'h12, 8'h34, 8'h56, 5'h0E}, 1, 0, 4'd0, 8'h0, 8'h0, 0, "R3");
        acc_mask = pack4(8'h00, 8'h00, 8'h00, 8'hFF);
        send({8'h12, 8'h34, 8'h56, 5'h0E}, 1, 0, 4'd0, 8'h0, 8'h0, 1, "R3");
        acc_mask = '0;
        send({8'h12, 8'h35, 8'h56, 5'h0F}, 1, 0, 4'd0, 8'h0, 8'h0, 0, "R3");

        // R4/R5: single, standard identifier with data test. Identifier 0x52B.
        acc_code = pack4(8'hA5, 8'h60, 8'h3C, 8'hC3);
        acc_mask = pack4(8'h00, 8'h0F, 8'h00, 8'h00);
        send(29'h52B, 0, 0, 4'd2, 8'h3C, 8'hC3, 1, "R4");
        send(29'h52A, 0, 0, 4'd2, 8'h3C, 8'hC3, 0, "R4");
        send(29'h52B, 0, 1, 4'd2, 8'h3C, 8'hC3, 0, "R4");
        acc_mask = pack4(8'h00, 8'h1F, 8'h00, 8'h00);
        send(29'h52B, 0, 1, 4'd2, 8'h3C, 8'hC3, 1, "R4");
        acc_code = pack4(8'hA5, 8'h70, 8'h3C, 8'hC3);
        acc_mask = pack4(8'h00, 8'h0F, 8'h00, 8'h00);
        send(29'h52B, 0, 1, 4'd2, 8'h00, 8'h00, 1, "R5");
        acc_code = pack4(8'hA5, 8'h60, 8'h3C, 8'hC3);
        send(29'h52B, 0, 0, 4'd0, 8'h00, 8'h00, 1, "R5");
        send(29'h52B, 0, 0, 4'd1, 8'h3C, 8'h00, 1, "R5");
        send(29'h52B, 0, 0, 4'd2, 8'h3C, 8'h00, 0, "R5");
        send(29'h52B, 0, 0, 4'd1, 8'h3D, 8'hC3, 0, "R5");
        acc_mask = pack4(8'h00, 8'h0F, 8'h01, 8'h80);
        send(29'h52B, 0, 0, 4'd3, 8'h3D, 8'h43, 1, "R5");

        // R6: dual, extended identifier bits 28..13.
        single_mode = 1'b0;
        acc_code = pack4(8'h11, 8'h22, 8'h33, 8'h44);
        acc_mask = '0;
        send({8'h11, 8'h22, 13'h1ABC}, 1, 0, 4'd0, 8'h0, 8'h0, 1, "R6");
        send({8'h33, 8'h44, 13'h0007}, 1, 0, 4'd0, 8'h0, 8'h0, 1, "R6");
        send({8'h11, 8'h44, 13'h0000}, 1, 0, 4'd0, 8'h0, 8'h0, 0, "R6");
        // R9: the same frame in the single arrangement misses the low bits.
        single_mode = 1'b1;
        send({8'h11, 8'h22, 13'h0000}, 1, 0, 4'd0, 8'h0, 8'h0, 0, "R9");
        single_mode = 1'b0;
        send({8'h11, 8'h22, 13'h0000}, 1, 0, 4'd0, 8'h0, 8'h0, 1, "R9");

        // R7/R8: dual, standard. Filter 1 id 0x4D5 rtr 0, data 0xC3; filter 2 id 0x2FA rtr 1.
        acc_code = pack4(8'h9A, 8'hAC, 8'h5F, 8'h53);
        acc_mask = '0;
        send(29'h4D5, 0, 0, 4'd1, 8'hC3, 8'h00, 1, "R7");
        send(29'h4D5, 0, 0, 4'd1, 8'hC2, 8'h00, 0, "R7");
        send(29'h4D5, 0, 0, 4'd0, 8'h00, 8'h00, 1, "R7");
        send(29'h4D5, 0, 1, 4'd1, 8'hC3, 8'h00, 0, "R7");
        acc_mask = pack4(8'h00, 8'h0F, 8'h00, 8'h00);
        send(29'h4D5, 0, 0, 4'd1, 8'h03, 8'h00, 1, "R7");
        acc_mask = '0;
        send(29'h2FA, 0, 1, 4'd3, 8'h77, 8'h00, 1, "R8");
        send(29'h2FA, 0, 0, 4'd3, 8'h77, 8'h00, 0, "R8");
        acc_mask = pack4(8'h00, 8'h00, 8'h00, 8'h10);
        send(29'h2FA, 0, 0, 4'd3, 8'h77, 8'h00, 1, "R8");

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1: results missing, actual %0d pending expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule